// File: doc/BRIEF.md
# Unified Funnel Shifter

This block is a purely combinational N-bit shifter, where N is a power of two. It performs six shift operations on one operand: zero-filling, sign-filling and rotating shifts, in both directions. The shift amount `k` always lies in the range 0 to N-1.

All six operations go through one shared window-extraction network. A field of 2N-1 bits is built from the operand and a fill pattern. The fill pattern depends on the shift kind and the direction. For a right shift the operand sits in the low half of the field. For a left shift it sits in the high half.

An N-bit window is then taken from the field at an offset. The network has log2(N) cascaded stages of 2-input multiplexers, and each stage is steered directly by one bit of the offset. The offset is `k` for a right shift and the bitwise inverse of `k` (equal to N-1-k) for a left shift. No adder and no select decoder are needed.

Top module: `funnel_shifter`

## Requirements
- R1: With `kind_i` = 0 (logical) and `dir_left_i` = 0, `res_o` equals `opnd_i` shifted right by `amt_i`, with the vacated upper bits set to 0.
- R2: With `kind_i` = 0 (logical) and `dir_left_i` = 1, `res_o` equals `opnd_i` shifted left by `amt_i`, with the vacated lower bits set to 0 and the bits shifted out above bit N-1 discarded.
- R3: With `kind_i` = 1 (arithmetic) and `dir_left_i` = 0, the vacated upper bits of `res_o` are copies of `opnd_i[N-1]`. For example, 1011 shifted right by 1 gives 1101.
- R4: With `kind_i` = 1 (arithmetic) and `dir_left_i` = 1, the result is identical to the logical left shift of R2.
- R5: With `kind_i` = 2 (rotate) and `dir_left_i` = 0, bit i of `res_o` equals bit (i+k) mod N of `opnd_i`.
- R6: With `kind_i` = 2 (rotate) and `dir_left_i` = 1, bit i of `res_o` equals bit (i-k) mod N of `opnd_i`.
- R7: When `amt_i` = 0, `res_o` equals `opnd_i` for every kind and both directions.
- R8: The unused kind code 3 behaves exactly like kind code 0 (logical) in both directions.
- R9: `res_o` depends only on the current inputs: it holds no state, and it follows any input change with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | N | Operand to be shifted |
| amt_i | input | log2(N) | Shift amount k, 0 to N-1 |
| dir_left_i | input | 1 | 1 = shift toward the MSB, 0 = shift toward the LSB |
| kind_i | input | 2 | 0 logical, 1 arithmetic, 2 rotate, 3 treated as logical |
| res_o | output | N | Shifted result |

## Verification
The bench builds two copies of the block, one with N=8 and one with N=4. Together they cover a three-stage and a two-stage multiplexer network. At these widths every operand, every shift amount, both directions and all four kind codes can be swept exhaustively. This makes every fill pattern and every offset of the field observable, including the sign-bit replication and the wrap-around of the rotates at the largest amount, N-1.

// File: rtl/funnel_pkg.sv
package funnel_pkg;

  typedef enum logic [1:0] {
    SHK_LOGIC  = 2'd0,
    SHK_ARITH  = 2'd1,
    SHK_ROTATE = 2'd2,
    SHK_SPARE  = 2'd3
  } shift_kind_e;

  function automatic logic kind_is_rotate(input logic [1:0] kind);
    return kind == SHK_ROTATE;
  endfunction

  function automatic logic kind_is_arith(input logic [1:0] kind);
    return kind == SHK_ARITH;
  endfunction

  // Code 3 has no operation of its own and is folded onto the logical shift.
  function automatic logic kind_is_zero_fill(input logic [1:0] kind);
    return (kind == SHK_LOGIC) || (kind == SHK_SPARE);
  endfunction

endpackage

// File: rtl/funnel_fill.sv
module funnel_fill #(
  parameter int N = 32
) (
  input  logic [N-1:0] opnd_i,
  input  logic [1:0]   kind_i,
  input  logic         dir_left_i,
  output logic [N-2:0] fill_o
);
  import funnel_pkg::*;

  always_comb begin
    fill_o = '0;
    if (dir_left_i) begin
      // The fill sits below the operand. Only a rotate brings the upper bits back in.
      if (kind_is_rotate(kind_i)) fill_o = opnd_i[N-1:1];
    end else begin
      // The fill sits above the operand.
      if (kind_is_rotate(kind_i))     fill_o = opnd_i[N-2:0];
      else if (kind_is_arith(kind_i)) fill_o = {(N-1){opnd_i[N-1]}};
    end
  end

endmodule

// File: rtl/funnel_field.sv
module funnel_field #(
  parameter int N  = 32,
  parameter int KW = $clog2(N),
  localparam int FW = 2*N-1
) (
  input  logic [N-1:0]  opnd_i,
  input  logic [N-2:0]  fill_i,
  input  logic [KW-1:0] amt_i,
  input  logic          dir_left_i,
  output logic [FW-1:0] field_o,
  output logic [KW-1:0] offset_o
);

  // For a power-of-two N, the inverse of k is N-1-k, so no adder is needed.
  function automatic logic [KW-1:0] window_offset(input logic [KW-1:0] k, input logic left);
    return left ? ~k : k;
  endfunction

  always_comb begin
    field_o  = dir_left_i ? {opnd_i, fill_i} : {fill_i, opnd_i};
    offset_o = window_offset(amt_i, dir_left_i);
  end

endmodule

// File: rtl/funnel_mux_stage.sv
module funnel_mux_stage #(
  parameter int FW    = 63,
  parameter int SHIFT = 1
) (
  input  logic [FW-1:0] din_i,
  input  logic          sel_i,
  output logic [FW-1:0] dout_o
);

  always_comb dout_o = sel_i ? (din_i >> SHIFT) : din_i;

endmodule

// File: rtl/funnel_window.sv
module funnel_window #(
  parameter int N  = 32,
  parameter int KW = $clog2(N),
  localparam int FW = 2*N-1
) (
  input  logic [FW-1:0] field_i,
  input  logic [KW-1:0] offset_i,
  output logic [N-1:0]  win_o
);

  logic [FW-1:0] lvl [0:KW];

  assign lvl[0] = field_i;

  // Stage b moves the field down by 2**b when bit b of the offset is set.
  for (genvar b = 0; b < KW; b++) begin : g_stage
    funnel_mux_stage #(
      .FW   (FW),
      .SHIFT(1 << b)
    ) u_stage (
      .din_i (lvl[b]),
      .sel_i (offset_i[b]),
      .dout_o(lvl[b+1])
    );
  end

  assign win_o = lvl[KW][N-1:0];

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter #(
  parameter int N = 32,
  localparam int KW = $clog2(N),
  localparam int FW = 2*N-1
) (
  input  logic [N-1:0]  opnd_i,
  input  logic [KW-1:0] amt_i,
  input  logic          dir_left_i,
  input  logic [1:0]    kind_i,
  output logic [N-1:0]  res_o
);

  // Named internal nets, brought out for the checker.
  logic [N-2:0]  fill_bits;
  logic [FW-1:0] funnel_field;
  logic [KW-1:0] win_offset;

  funnel_fill #(.N(N)) u_fill (
    .opnd_i    (opnd_i),
    .kind_i    (kind_i),
    .dir_left_i(dir_left_i),
    .fill_o    (fill_bits)
  );

  funnel_field #(.N(N), .KW(KW)) u_field (
    .opnd_i    (opnd_i),
    .fill_i    (fill_bits),
    .amt_i     (amt_i),
    .dir_left_i(dir_left_i),
    .field_o   (funnel_field),
    .offset_o  (win_offset)
  );

  funnel_window #(.N(N), .KW(KW)) u_window (
    .field_i (funnel_field),
    .offset_i(win_offset),
    .win_o   (res_o)
  );

endmodule

// File: rtl/funnel_shifter_chk.sv
module funnel_shifter_chk #(
  parameter int N = 32,
  localparam int KW = $clog2(N)
) (
  input logic [N-1:0]  opnd_i,
  input logic [KW-1:0] amt_i,
  input logic          dir_left_i,
  input logic [1:0]    kind_i,
  input logic [N-1:0]  res_o,
  input logic [KW-1:0] win_offset
);

  logic [N-1:0] all_ones;
  logic [N-1:0] low_mask;
  logic [N-1:0] high_mask;
  logic         known;

  always_comb begin
    all_ones  = '1;
    low_mask  = ~(all_ones << amt_i);
    high_mask = ~(all_ones >> amt_i);
    known     = !$isunknown({opnd_i, amt_i, dir_left_i, kind_i});
  end

  always_comb begin
    if (known) begin
      AST_ZERO_AMT_IDENTITY: assert (amt_i != '0 || res_o == opnd_i); // R7
      AST_ROTATE_KEEPS_ONES: assert (kind_i != 2'd2 || $countones(res_o) == $countones(opnd_i)); // R5
      AST_LEFT_LOW_CLEAR: assert (!dir_left_i || kind_i == 2'd2 || (res_o & low_mask) == '0); // R2
      AST_RIGHT_HIGH_CLEAR: assert (dir_left_i || !(kind_i == 2'd0 || kind_i == 2'd3) || (res_o & high_mask) == '0); // R1
      AST_ARITH_SIGN_KEPT: assert (dir_left_i || kind_i != 2'd1 || res_o[N-1] == opnd_i[N-1]); // R3
      AST_LEFT_OFFSET_SUM: assert (!dir_left_i || int'(win_offset) + int'(amt_i) == N-1); // R6
      AST_RIGHT_OFFSET_EQ: assert (dir_left_i || win_offset == amt_i); // R5
    end
  end

endmodule

bind funnel_shifter funnel_shifter_chk #(.N(N)) u_chk (
  .opnd_i    (opnd_i),
  .amt_i     (amt_i),
  .dir_left_i(dir_left_i),
  .kind_i    (kind_i),
  .res_o     (res_o),
  .win_offset(win_offset)
);

// File: tb/sim_funnel_shifter.sv
module sim_funnel_shifter;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] a8;
  logic [2:0] k8;
  logic       l8;
  logic [1:0] t8;
  logic [7:0] y8;

  logic [3:0] a4;
  logic [1:0] k4;
  logic       l4;
  logic [1:0] t4;
  logic [3:0] y4;

  funnel_shifter #(.N(8)) u0 (
    .opnd_i(a8), .amt_i(k8), .dir_left_i(l8), .kind_i(t8), .res_o(y8)
  );

  funnel_shifter #(.N(4)) u1 (
    .opnd_i(a4), .amt_i(k4), .dir_left_i(l4), .kind_i(t4), .res_o(y4)
  );

  // Bit-by-bit model: each result bit names its source bit, or a fill bit.
  function automatic logic [7:0] model(input logic [7:0] a, input int n, input int k,
                                       input bit left, input int kind);
    logic [7:0] r = '0;
    for (int i = 0; i < n; i++) begin
      int src = left ? i - k : i + k;
      if (kind == 2)                 r[i] = a[(src + n) % n];
      else if (src >= 0 && src < n)  r[i] = a[src];
      else if (kind == 1 && !left)   r[i] = a[n-1];
      else                           r[i] = 1'b0;
    end
    return r;
  endfunction

  function automatic string tag_of(input int k, input bit left, input int kind);
    if (k == 0)    return "R7";
    if (kind == 3) return "R8";
    if (kind == 0) return left ? "R2" : "R1";
    if (kind == 1) return left ? "R4" : "R3";
    return left ? "R6" : "R5";
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin : watchdog
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    a8 = '0; k8 = '0; l8 = 1'b0; t8 = '0;
    a4 = '0; k4 = '0; l4 = 1'b0; t4 = '0;
    @(negedge clk);
    check("R7", y8, 8'h00);
    check("R7", {4'h0, y4}, 8'h00);

    // Worked examples on the 4-bit copy.
    a4 = 4'b1011; k4 = 2'd1;
    l4 = 1'b0; t4 = 2'd0; #1 check("R1", {4'h0, y4}, 8'b0101);
    l4 = 1'b1; t4 = 2'd0; #1 check("R2", {4'h0, y4}, 8'b0110);
    l4 = 1'b0; t4 = 2'd1; #1 check("R3", {4'h0, y4}, 8'b1101);
    l4 = 1'b1; t4 = 2'd1; #1 check("R4", {4'h0, y4}, 8'b0110);
    l4 = 1'b0; t4 = 2'd2; #1 check("R5", {4'h0, y4}, 8'b1101);
    l4 = 1'b1; t4 = 2'd2; #1 check("R6", {4'h0, y4}, 8'b0111);

    // R9: the output follows an input change with no clock edge in between.
    @(posedge clk);
    #1 a8 = 8'h81; k8 = 3'd7; l8 = 1'b0; t8 = 2'd1;
    #1 check("R9", y8, 8'hFF);
    a8 = 8'h01;
    #1 check("R9", y8, 8'h00);

    // Exhaustive sweep, N=4.
    for (int t = 0; t < 4; t++)
      for (int d = 0; d < 2; d++)
        for (int k = 0; k < 4; k++)
          for (int a = 0; a < 16; a++) begin
            @(posedge clk);
            a4 = a[3:0]; k4 = k[1:0]; l4 = d[0]; t4 = t[1:0];
            @(negedge clk);
            check(tag_of(k, d[0], t), {4'h0, y4}, model({4'h0, a[3:0]}, 4, k, d[0], t));
          end

    // Exhaustive sweep, N=8.
    for (int t = 0; t < 4; t++)
      for (int d = 0; d < 2; d++)
        for (int k = 0; k < 8; k++)
          for (int a = 0; a < 256; a++) begin
            @(posedge clk);
            a8 = a[7:0]; k8 = k[2:0]; l8 = d[0]; t8 = t[1:0];
            @(negedge clk);
            check(tag_of(k, d[0], t), y8, model(a[7:0], 8, k, d[0], t));
          end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule